// File: doc/BRIEF.md
# Configuration File Header Parser

This block takes a programmable-logic configuration file as a byte stream and checks and decodes its header before the raw configuration data begins. The header opens with a fixed 13-byte signature. Four tagged text sections follow, each with its own length, and the block captures each of them into a buffer of fixed size. A tagged 32-bit length for the configuration data comes last. Once the header has been accepted, the block passes the configuration bytes straight through to a downstream port. It stops taking input when the declared number of bytes has gone through.

The block reports any of four faults: a corrupt signature, a text section too long for its buffer, a missing length tag, or a stream that ends early. When it finds a fault it stops accepting input. The fault stays latched with its code until a synchronous reset. The block does not interpret the text fields or the configuration data, and it does not check any checksum.

Top module: `cfg_hdr_parser`

## Requirements
- R1: The first 13 accepted bytes must be 0x00 0x09 0x0F 0xF0 0x0F 0xF0 0x0F 0xF0 0x0F 0xF0 0x00 0x00 0x01 in that order. On the first byte that differs, the block sets `err_code` to 1 in the cycle after that byte is accepted.
- R2: After the signature come four text sections, in this order: design name, device name, date, time. Each one is a tag byte of any value, then a 16-bit length sent high byte first, then that many characters. Character k of a section is stored at bits [8k+7:8k] of its output.
- R3: Every byte position of a text output at or above the received character count reads zero. This includes the terminator position equal to the length.
- R4: A text length equal to or greater than TEXT_CAP (default 64) sets `err_code` to 2 when its low length byte is accepted. Lengths up to TEXT_CAP-1 are accepted.
- R5: The byte after the fourth text section must be 0x65 (ASCII 'e'). Any other value sets `err_code` to 3.
- R6: After the 0x65 tag come four bytes, high byte first, that make up `payload_len`. `hdr_done` is high for exactly one cycle, the cycle after the last of these bytes is accepted.
- R7: While payload bytes are being forwarded, `out_valid` follows `in_valid`, `out_data` follows `in_data`, and `in_ready` follows `out_ready`, all in the same cycle.
- R8: Once `payload_len` payload bytes have been forwarded, `in_ready` stays low. With a length of zero, no byte is forwarded after the header.
- R9: If `in_last` comes with an accepted byte that is not the final byte of the file, `err_code` is set to 4. If the same byte also breaks rule R1, R4 or R5, that rule's code is reported instead.
- R10: Once `err_code` is non-zero, `err` stays high, `err_code` holds its value and `in_ready` stays low until reset.
- R11: Synchronous active-low reset clears the text outputs, `payload_len`, `err`, `err_code` and `hdr_done`, and sends the block back to signature matching with `in_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the last byte of the input stream |
| in_ready | output | 1 | Block accepts the input byte |
| out_valid | output | 1 | Forwarded payload byte valid |
| out_data | output | 8 | Forwarded payload byte |
| out_ready | input | 1 | Downstream accepts the payload byte |
| design_name | output | TEXT_CAP*8 | First text section, zero padded |
| device_name | output | TEXT_CAP*8 | Second text section, zero padded |
| build_date | output | TEXT_CAP*8 | Third text section, zero padded |
| build_time | output | TEXT_CAP*8 | Fourth text section, zero padded |
| payload_len | output | 32 | Declared payload length |
| hdr_done | output | 1 | One-cycle pulse when the header is complete |
| err | output | 1 | A fault has been latched |
| err_code | output | 3 | 0 none, 1 signature, 2 text too long, 3 bad length tag, 4 early end |

## Verification
A wrong position in the header walk can show up in two ways. `in_ready` may stay high or drop one byte too early or too late, or a fault code may appear on a byte where the stream is legal. The cycle-by-cycle comparison catches either in the cycle it happens. A wrong text or length counter shows up as `hdr_done` arriving on the wrong byte, or as payload forwarding that starts or stops a byte off, which is visible in `out_valid` at once. Wrong character placement or missing zero padding only shows in the text outputs, and these are compared after each stream has finished.

// File: rtl/cfg_hdr_pkg.sv
// Package: shared phase, fault codes and signature lookup for the header parser.
// Assumes: byte-wide input; signature length is fixed by the file format.
package cfg_hdr_pkg;

    typedef enum logic [3:0] {
        ST_SIG, ST_TAG, ST_LHI, ST_LLO, ST_TEXT,
        ST_ETAG, ST_PLEN, ST_PAY, ST_DONE, ST_FAIL
    } phase_t;

    typedef enum logic [2:0] {
        E_NONE  = 3'd0,
        E_SIG   = 3'd1,
        E_BUF   = 3'd2,
        E_TAG   = 3'd3,
        E_TRUNC = 3'd4
    } fault_t;

    localparam int          SIG_LEN  = 13;
    localparam int          NFIELD   = 4;
    localparam logic [7:0]  LEN_TAG  = 8'h65;

    // Expected signature byte at a given position.
    function automatic logic [7:0] sig_byte(input int pos);
        case (pos)
            1:          return 8'h09;
            2, 4, 6, 8: return 8'h0F;
            3, 5, 7, 9: return 8'hF0;
            12:         return 8'h01;
            default:    return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cfg_text_field.sv
// Module: one text capture buffer. Writes a character at an index and
// zeroes the following slot so the text always ends in a terminator.
// Assumes: index never exceeds TEXT_CAP-2 (length checked upstream).
module cfg_text_field #(
    parameter int TEXT_CAP = 64,
    localparam int IDXW    = $clog2(TEXT_CAP)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDXW-1:0]       wr_idx,
    input  logic [7:0]            wr_char,
    output logic [TEXT_CAP*8-1:0] text_o
);

    logic [TEXT_CAP*8-1:0] store_q;

    // Capture a character and place a terminator behind it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q <= '0;
        end else if (wr_en) begin
            store_q[int'(wr_idx)*8 +: 8] <= wr_char;
            if (int'(wr_idx) + 1 < TEXT_CAP)
                store_q[(int'(wr_idx) + 1)*8 +: 8] <= 8'h00;
        end
    end

    assign text_o = store_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_idx) < TEXT_CAP - 1)); // R4

endmodule

// File: rtl/cfg_payload_counter.sv
// Module: counts forwarded payload bytes and flags the final one.
// Assumes: len is stable and non-zero while inc is asserted.
module cfg_payload_counter (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        inc,
    input  logic [31:0] len,
    output logic        final_o
);

    logic [31:0] cnt_q;

    // Count bytes forwarded since the header finished.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt_q <= '0;
        else if (inc)
            cnt_q <= cnt_q + 32'd1;
    end

    assign final_o = (cnt_q == len - 32'd1);

    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> (cnt_q < len)); // R8

endmodule

// File: rtl/cfg_hdr_parser.sv
// Module: configuration file header parser. Matches the signature, walks
// four length-prefixed text sections, checks the length tag, reads the
// 32-bit payload length, then forwards that many bytes downstream.
// Assumes: one byte per accepted beat; faults are sticky until reset.
module cfg_hdr_parser
    import cfg_hdr_pkg::*;
#(
    parameter int TEXT_CAP = 64,
    localparam int IDXW    = $clog2(TEXT_CAP)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [7:0]            in_data,
    input  logic                  in_last,
    output logic                  in_ready,
    output logic                  out_valid,
    output logic [7:0]            out_data,
    input  logic                  out_ready,
    output logic [TEXT_CAP*8-1:0] design_name,
    output logic [TEXT_CAP*8-1:0] device_name,
    output logic [TEXT_CAP*8-1:0] build_date,
    output logic [TEXT_CAP*8-1:0] build_time,
    output logic [31:0]           payload_len,
    output logic                  hdr_done,
    output logic                  err,
    output logic [2:0]            err_code
);

    localparam logic [15:0] CAP16   = 16'(TEXT_CAP);
    localparam logic [3:0]  SIG_TOP = 4'(SIG_LEN - 1);

    phase_t          phase, nxt_phase;
    fault_t          fault_q, nxt_fault;
    logic [3:0]      sig_idx;
    logic [1:0]      pl_idx;
    logic [1:0]      fidx;
    logic [7:0]      len_hi;
    logic [15:0]     flen;
    logic [IDXW-1:0] tidx;
    logic [31:0]     plen_q;
    logic            hdr_q;
    logic            acc;
    logic            pay_final;
    logic [15:0]     tidx_ext;
    logic [15:0]     len_now;
    logic [NFIELD-1:0]    field_we;
    logic [TEXT_CAP*8-1:0] fbuf [NFIELD];

    assign tidx_ext = 16'(tidx);
    assign len_now  = {len_hi, in_data};

    // Input acceptance depends on the phase; payload is gated by downstream.
    always_comb begin
        case (phase)
            ST_SIG, ST_TAG, ST_LHI, ST_LLO,
            ST_TEXT, ST_ETAG, ST_PLEN: in_ready = 1'b1;
            ST_PAY:                    in_ready = out_ready;
            default:                   in_ready = 1'b0;
        endcase
    end

    assign acc       = in_valid && in_ready;
    assign out_valid = (phase == ST_PAY) && in_valid;
    assign out_data  = in_data;

    // Decide the next phase and fault code for the byte being accepted.
    always_comb begin
        nxt_phase = phase;
        nxt_fault = fault_q;
        case (phase)
            ST_SIG: begin
                if (in_data != sig_byte(int'(sig_idx))) begin
                    nxt_phase = ST_FAIL;
                    nxt_fault = E_SIG;
                end else if (sig_idx == SIG_TOP) begin
                    nxt_phase = ST_TAG;
                end
            end
            ST_TAG: nxt_phase = ST_LHI;
            ST_LHI: nxt_phase = ST_LLO;
            ST_LLO: begin
                if (len_now >= CAP16) begin
                    nxt_phase = ST_FAIL;
                    nxt_fault = E_BUF;
                end else if (len_now == 16'd0) begin
                    nxt_phase = (fidx == 2'd3) ? ST_ETAG : ST_TAG;
                end else begin
                    nxt_phase = ST_TEXT;
                end
            end
            ST_TEXT: begin
                if (tidx_ext + 16'd1 == flen)
                    nxt_phase = (fidx == 2'd3) ? ST_ETAG : ST_TAG;
            end
            ST_ETAG: begin
                if (in_data != LEN_TAG) begin
                    nxt_phase = ST_FAIL;
                    nxt_fault = E_TAG;
                end else begin
                    nxt_phase = ST_PLEN;
                end
            end
            ST_PLEN: begin
                if (pl_idx == 2'd3)
                    nxt_phase = ({plen_q[23:0], in_data} == 32'd0) ? ST_DONE : ST_PAY;
            end
            ST_PAY: begin
                if (pay_final) nxt_phase = ST_DONE;
            end
            default: ;
        endcase
        if (in_last && nxt_phase != ST_DONE && nxt_phase != ST_FAIL) begin
            nxt_phase = ST_FAIL;
            nxt_fault = E_TRUNC;
        end
    end

    // Advance the header walk and capture lengths on each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= ST_SIG;
            fault_q <= E_NONE;
            sig_idx <= '0;
            pl_idx  <= '0;
            fidx    <= '0;
            len_hi  <= '0;
            flen    <= '0;
            tidx    <= '0;
            plen_q  <= '0;
            hdr_q   <= 1'b0;
        end else begin
            hdr_q <= 1'b0;
            if (acc) begin
                phase   <= nxt_phase;
                fault_q <= nxt_fault;
                case (phase)
                    ST_SIG: sig_idx <= sig_idx + 4'd1;
                    ST_LHI: len_hi  <= in_data;
                    ST_LLO: begin
                        flen <= len_now;
                        tidx <= '0;
                        if (len_now == 16'd0) fidx <= fidx + 2'd1;
                    end
                    ST_TEXT: begin
                        tidx <= tidx + 1'b1;
                        if (tidx_ext + 16'd1 == flen) fidx <= fidx + 2'd1;
                    end
                    ST_PLEN: begin
                        plen_q <= {plen_q[23:0], in_data};
                        pl_idx <= pl_idx + 2'd1;
                        if (pl_idx == 2'd3) hdr_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    cfg_payload_counter u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (acc && phase == ST_PLEN),
        .inc     (acc && phase == ST_PAY),
        .len     (plen_q),
        .final_o (pay_final)
    );

    // One capture buffer per text section.
    for (genvar g = 0; g < NFIELD; g++) begin : g_field
        assign field_we[g] = acc && (phase == ST_TEXT) && (fidx == 2'(g));
        cfg_text_field #(.TEXT_CAP(TEXT_CAP)) u_fld (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (field_we[g]),
            .wr_idx  (tidx),
            .wr_char (in_data),
            .text_o  (fbuf[g])
        );
    end

    assign design_name = fbuf[0];
    assign device_name = fbuf[1];
    assign build_date  = fbuf[2];
    assign build_time  = fbuf[3];
    assign payload_len = plen_q;
    assign hdr_done    = hdr_q;
    assign err_code    = fault_q;
    assign err         = (fault_q != E_NONE);

    AST_SIG_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_SIG && acc && in_data != sig_byte(int'(sig_idx)))
        |=> (err_code == 3'd1)); // R1
    AST_TAG_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_ETAG && acc && in_data != LEN_TAG)
        |=> (err_code == 3'd3)); // R5
    AST_HDR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_done |=> !hdr_done); // R6
    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (err && $stable(err_code))); // R10
    AST_ERR_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !in_ready); // R10

endmodule

// File: tb/cfg_hdr_parser_bench.sv
module cfg_hdr_parser_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CAP        = 64;
    localparam int FW         = CAP * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_data = 8'h00;
    logic          in_last = 1'b0;
    logic          in_ready;
    logic          out_valid;
    logic [7:0]    out_data;
    logic          out_ready = 1'b0;
    logic [FW-1:0] f_out [4];
    logic [31:0]   payload_len;
    logic          hdr_done, err;
    logic [2:0]    err_code;

    cfg_hdr_parser #(.TEXT_CAP(CAP)) u_cfg_hdr_parser (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_ready(in_ready), .out_valid(out_valid),
        .out_data(out_data), .out_ready(out_ready),
        .design_name(f_out[0]), .device_name(f_out[1]),
        .build_date(f_out[2]), .build_time(f_out[3]),
        .payload_len(payload_len), .hdr_done(hdr_done),
        .err(err), .err_code(err_code)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [7:0] SIGB [13] = '{8'h00, 8'h09, 8'h0F, 8'hF0, 8'h0F, 8'hF0, 8'h0F,
                              8'hF0, 8'h0F, 8'hF0, 8'h00, 8'h00, 8'h01};

    logic [7:0]    bq [$];
    int            n, code, total, hdr_len;
    logic [31:0]   exp_plen;
    logic [FW-1:0] exp_f [4];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [FW-1:0] act, input logic [FW-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Behavioural reading of the stream: fault, bytes taken, header end.
    task automatic model();
        int p, len;
        logic [31:0] pl;
        n = bq.size(); code = 0; hdr_len = -1; total = 0; exp_plen = 0;
        for (int f = 0; f < 4; f++) exp_f[f] = '0;
        p = 0;
        for (int i = 0; i < 13; i++) begin
            if (bq[p] !== SIGB[i]) begin code = 1; total = p + 1; return; end
            if (p == n - 1) begin code = 4; total = n; return; end
            p++;
        end
        for (int f = 0; f < 4; f++) begin
            if (p == n - 1) begin code = 4; total = n; return; end
            p++;
            len = int'(bq[p]) * 256;
            if (p == n - 1) begin code = 4; total = n; return; end
            p++;
            len = len + int'(bq[p]);
            if (len >= CAP) begin code = 2; total = p + 1; return; end
            if (p == n - 1) begin code = 4; total = n; return; end
            p++;
            for (int c = 0; c < len; c++) begin
                exp_f[f][8*c +: 8] = bq[p];
                if (p == n - 1) begin code = 4; total = n; return; end
                p++;
            end
        end
        if (bq[p] != 8'h65) begin code = 3; total = p + 1; return; end
        if (p == n - 1) begin code = 4; total = n; return; end
        p++;
        pl = 0;
        for (int b = 0; b < 4; b++) begin
            pl = {pl[23:0], bq[p]};
            if (b == 3) begin hdr_len = p + 1; exp_plen = pl; end
            if (p == n - 1 && !(b == 3 && pl == 0)) begin code = 4; total = n; return; end
            p++;
        end
        if (pl == 0) begin total = hdr_len; return; end
        for (longint j = 0; j < longint'(pl); j++) begin
            if (p == n - 1 && j != longint'(pl) - 1) begin code = 4; total = n; return; end
            p++;
        end
        total = p;
    endtask

    task automatic push_sig();
        for (int i = 0; i < 13; i++) bq.push_back(SIGB[i]);
    endtask

    task automatic push_text(input logic [7:0] tag, input string s);
        bq.push_back(tag);
        bq.push_back(8'(s.len() >> 8));
        bq.push_back(8'(s.len()));
        for (int i = 0; i < s.len(); i++) bq.push_back(s[i]);
    endtask

    task automatic push_text_n(input logic [7:0] tag, input int len, input int nch);
        bq.push_back(tag);
        bq.push_back(8'(len >> 8));
        bq.push_back(8'(len));
        for (int i = 0; i < nch; i++) bq.push_back(8'(8'h61 + i % 26));
    endtask

    task automatic push_len(input logic [7:0] tag, input logic [31:0] v);
        bq.push_back(tag);
        bq.push_back(v[31:24]); bq.push_back(v[23:16]);
        bq.push_back(v[15:8]);  bq.push_back(v[7:0]);
    endtask

    task automatic push_pay(input int m);
        for (int i = 0; i < m; i++) bq.push_back(8'(i * 37 + 5));
    endtask

    task automatic run_test(input string name, input string rtag);
        int k, extra;
        bit just, acc, e_rdy, e_ov, e_err, e_hdr;
        model();
        // reset and check the cleared state (R11)
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0;
        @(posedge clk);
        @(negedge clk);
        #1;
        for (int f = 0; f < 4; f++)
            chk(f_out[f] == '0, "R11", {name, " text cleared"}, f_out[f], '0);
        chk(payload_len == 0 && !err && err_code == 0 && !hdr_done, "R11",
            {name, " flags cleared"}, {err, err_code, hdr_done}, '0);
        chk(in_ready == 1'b1, "R11", {name, " ready after reset"}, FW'(in_ready), FW'(1));
        rst_n = 1'b1;
        k = 0; extra = 0; just = 1'b0;
        while ((k < total || extra < 6) && cyc < 150000) begin
            @(negedge clk);
            in_valid  = (k < n) && ($urandom_range(0, 3) != 0);
            in_data   = (k < n) ? bq[k] : 8'h00;
            in_last   = (k == n - 1);
            out_ready = ($urandom_range(0, 4) != 0);
            #1;
            e_rdy = (k < total) && (hdr_len < 0 || k < hdr_len || out_ready);
            e_ov  = in_valid && hdr_len >= 0 && k >= hdr_len && k < total;
            e_err = (code != 0) && (k >= total);
            e_hdr = just && hdr_len >= 0 && k == hdr_len;
            chk(in_ready == e_rdy, "R8", {name, " in_ready"}, FW'(in_ready), FW'(e_rdy));
            chk(out_valid == e_ov, "R7", {name, " out_valid"}, FW'(out_valid), FW'(e_ov));
            if (e_ov)
                chk(out_data == in_data, "R7", {name, " out_data"}, FW'(out_data), FW'(in_data));
            chk(err == e_err, "R10", {name, " err"}, FW'(err), FW'(e_err));
            chk(err_code == (e_err ? 3'(code) : 3'd0), "R10", {name, " err_code"},
                FW'(err_code), FW'(e_err ? code : 0));
            chk(hdr_done == e_hdr, "R6", {name, " hdr_done"}, FW'(hdr_done), FW'(e_hdr));
            acc = in_valid && e_rdy;
            @(posedge clk);
            just = acc;
            if (acc) k++;
            if (k >= total) extra++;
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        #1;
        for (int f = 0; f < 4; f++)
            chk(f_out[f] == exp_f[f], "R2 R3", {name, " text field"}, f_out[f], exp_f[f]);
        chk(err_code == 3'(code), rtag, {name, " final code"}, FW'(err_code), FW'(code));
        if (hdr_len >= 0)
            chk(payload_len == exp_plen, "R6", {name, " payload_len"},
                FW'(payload_len), FW'(exp_plen));
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R2 R6 R7: regular file, short fields, five payload bytes
        bq.delete(); push_sig();
        push_text(8'h61, "top_wrap.ncd"); push_text(8'h62, "dev7a");
        push_text(8'h63, "2024/01/31");  push_text(8'h64, "12:00:00");
        push_len(8'h65, 32'd5); push_pay(5);
        run_test("normal", "R2");

        // R1: signature byte 7 corrupted
        bq.delete(); push_sig(); bq[7] = 8'hF1;
        push_text(8'h61, "x"); push_pay(8);
        run_test("badsig", "R1");

        // R4: length TEXT_CAP-1 accepted at the boundary
        bq.delete(); push_sig();
        push_text_n(8'h00, CAP - 1, CAP - 1); push_text(8'hFF, "p");
        push_text(8'h11, "d"); push_text(8'h22, "");
        push_len(8'h65, 32'd3); push_pay(3);
        run_test("cap_minus1", "R4");

        // R4: length equal to TEXT_CAP rejected in the date section
        bq.delete(); push_sig();
        push_text(8'h61, "nm"); push_text(8'h62, "pt");
        push_text_n(8'h63, CAP, 10);
        run_test("overflow", "R4");

        // R5: wrong length tag
        bq.delete(); push_sig();
        push_text(8'h61, "a"); push_text(8'h62, "b");
        push_text(8'h63, "c"); push_text(8'h64, "d");
        push_len(8'h66, 32'd2); push_pay(2);
        run_test("badtag", "R5");

        // R9: stream ends in the middle of the payload
        bq.delete(); push_sig();
        push_text(8'h61, "ab"); push_text(8'h62, "cd");
        push_text(8'h63, "ef"); push_text(8'h64, "gh");
        push_len(8'h65, 32'd10); push_pay(4);
        run_test("trunc_pay", "R9");

        // R8: empty sections and zero payload, trailing bytes refused
        bq.delete(); push_sig();
        push_text(8'h61, ""); push_text(8'h62, "");
        push_text(8'h63, ""); push_text(8'h64, "");
        push_len(8'h65, 32'd0); push_pay(4);
        run_test("zero_len", "R8");

        // R6 R8: big-endian length 258, five extra bytes refused
        bq.delete(); push_sig();
        push_text(8'h61, "long"); push_text(8'h62, "dv");
        push_text(8'h63, "dt"); push_text(8'h64, "tm");
        push_len(8'h65, 32'h0000_0102); push_pay(263);
        run_test("long_pay", "R6");

        // R9: stream ends on the bad tag byte, tag fault wins
        bq.delete(); push_sig();
        push_text(8'h61, "a"); push_text(8'h62, "b");
        push_text(8'h63, "c"); push_text(8'h64, "d");
        bq.push_back(8'h45);
        run_test("last_on_badtag", "R9");

        // R9: stream ends inside the signature
        bq.delete();
        for (int i = 0; i < 6; i++) bq.push_back(SIGB[i]);
        run_test("trunc_sig", "R9");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule